// File: doc/BRIEF.md
# Masked Block-Write Datapath for a 16-bit Video DRAM

This block sits between the cycle decoder of a 16-bit video DRAM and its storage array model. For each accepted write cycle it works out which columns get written, which of the 16 data bits in those columns may change, and what value is written. A plain write targets one column and takes its value from the data bus. A block write fills a group of adjacent columns (4 or 8, set by a parameter) with the contents of a stored color register. Each column in the group is switched on or off by one data-bus bit.

Both kinds of write can be restricted per bit. In the live mode the bit mask is the data-bus value captured when the row strobe fell. In the held mode the mask comes from a stored write-mask register, and the captured value is ignored. Two load cycles fill the color register and the write-mask register from the data bus. They write nothing to the array.

The cycle input is a valid-only stream. The block has no ready signal and never applies back-pressure: every beat with `cyc_valid_i` high is consumed on that clock edge. The result goes out as a single-cycle beat on the next clock. Only the enables mark it, so an array model must act on the outputs in exactly that cycle.

Top module: `blkwr_datapath`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, all outputs are zero. Reset also clears the color register and the write-mask register to 0x0000, so a block write before any load writes 0x0000, and a held-mode masked write has `bit_en_o` = 0x0000.
- R2: Cycle code 6 (load color) stores `dq_i` into the color register. Cycle code 5 (load mask) stores `dq_i` into the write-mask register. Neither cycle raises any enable. A stored value is used by a write accepted on the very next clock.
- R3: Cycle code 1 (plain write) gives the following, whatever `ras_dq_i` and `persist_i` hold:
  - `col_en_o` = lane 0 only.
  - lane 0 address = `col_addr_i`.
  - `bit_en_o` = 0xFFFF.
  - `wr_data_o` = `dq_i`.
- R4: Cycle codes 2 (masked write) and 4 (masked block write) with `persist_i` = 0 give `bit_en_o` = `ras_dq_i`. A 1 in the mask enables that data bit.
- R5: Cycle codes 2 and 4 with `persist_i` = 1 give `bit_en_o` = the write-mask register, and `ras_dq_i` has no effect.
- R6: Cycle codes 3 (block write) and 4 behave as follows:
  - Lane i is the column whose address is `col_addr_i[8:LB]` followed by the LB-bit index i, where LB = log2(BLK_COLS).
  - `col_en_o[i]` = `dq_i[i]`, and data-bus bits at or above BLK_COLS are ignored.
  - `wr_data_o` = the color register, not `dq_i`.
  - Code 3 gives `bit_en_o` = 0xFFFF.
- R7: Code 2 shares the single-column lane layout of R3 but takes its bit mask from R4 or R5. Code 4 shares the lane layout of R6 but takes its bit mask from R4 or R5.
- R8: The outputs carry a cycle's result for exactly one clock, the one after the accepting edge. In every other clock, including cycles with `cyc_valid_i` low and accepted beats with code 0, 5, 6 or 7, `col_en_o`, `bit_en_o` and `wr_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid_i | input | 1 | A cycle beat is present; it is always accepted |
| cyc_code_i | input | 3 | Cycle code: 0 none, 1 write, 2 masked write, 3 block, 4 masked block, 5 load mask, 6 load color, 7 none |
| persist_i | input | 1 | Held-mask mode flag from the decoder |
| col_addr_i | input | 9 | Latched column address |
| ras_dq_i | input | 16 | Data bus as sampled at row strobe fall |
| dq_i | input | 16 | Data bus as latched for this cycle |
| lane_addr_o | output | 36 | Column address per lane, lane i at bits [9i+8:9i] |
| col_en_o | output | 4 | Column write enable per lane |
| bit_en_o | output | 16 | Per-bit write enable |
| wr_data_o | output | 16 | Value written to every enabled column |

## Verification
The bench aims at the points where the mask sources and data sources could get mixed up:
- A design that always used the captured row-strobe value would fail the held-mode cases, which set `ras_dq_i` to all ones. A design that masked plain writes would fail when `persist_i` is high on a code-1 cycle.
- Block writes load a color that differs from `dq_i` and set data-bus bits above the lane count. A design that writes the bus or decodes too many column-mask bits shows up here.
- A load followed directly by a masked write checks that the new mask is used at once.
- Idle cycles after each write, and a beat held low with a write code on the bus, catch enables that stay high for more than one clock.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE      = 3'd0,
    CYC_PLAIN     = 3'd1,
    CYC_PLAIN_BM  = 3'd2,
    CYC_BLOCK     = 3'd3,
    CYC_BLOCK_BM  = 3'd4,
    CYC_LOAD_MASK = 3'd5,
    CYC_LOAD_CLR  = 3'd6,
    CYC_SPARE     = 3'd7
  } cyc_code_e;

  typedef struct packed {
    logic writes;     // single-column write of any flavour
    logic blocks;     // multi-column write of any flavour
    logic bitmasked;  // per-bit mask applies
    logic ld_mask;
    logic ld_color;
  } cyc_class_t;

  function automatic cyc_class_t classify(input logic [2:0] code);
    cyc_class_t c;
    c = '0;
    unique case (cyc_code_e'(code))
      CYC_PLAIN:     c.writes = 1'b1;
      CYC_PLAIN_BM:  begin c.writes = 1'b1; c.bitmasked = 1'b1; end
      CYC_BLOCK:     c.blocks = 1'b1;
      CYC_BLOCK_BM:  begin c.blocks = 1'b1; c.bitmasked = 1'b1; end
      CYC_LOAD_MASK: c.ld_mask = 1'b1;
      CYC_LOAD_CLR:  c.ld_color = 1'b1;
      default:       c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/blkwr_store.sv
module blkwr_store #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_mask,
  input  logic          ld_color,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] color_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      color_q <= '0;
    end else begin
      if (ld_mask)  mask_q  <= din;
      if (ld_color) color_q <= din;
    end
  end

  AST_COLOR_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_color |=> color_q == $past(din)); // R2
  AST_MASK_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mask |=> mask_q == $past(din)); // R2
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mask |=> $stable(mask_q)); // R5

endmodule

// File: rtl/blkwr_bitsel.sv
module blkwr_bitsel #(
  parameter int DW = 16
) (
  input  logic          bitmasked,
  input  logic          persist,
  input  logic [DW-1:0] ras_dq,
  input  logic [DW-1:0] mask_q,
  output logic [DW-1:0] bit_en
);

  always_comb begin
    if (!bitmasked)   bit_en = '1;
    else if (persist) bit_en = mask_q;
    else              bit_en = ras_dq;
  end

endmodule

// File: rtl/blkwr_lanes.sv
module blkwr_lanes #(
  parameter int DW       = 16,
  parameter int AW       = 9,
  parameter int BLK_COLS = 4
) (
  input  logic                   blocks,
  input  logic [AW-1:0]          col_addr,
  input  logic [DW-1:0]          dq,
  output logic [BLK_COLS*AW-1:0] lane_addr,
  output logic [BLK_COLS-1:0]    lane_en
);

  localparam int LB  = $clog2(BLK_COLS);
  localparam int BAW = AW - LB;

  logic [BAW-1:0] blk_base;
  assign blk_base = col_addr[AW-1:LB];

  for (genvar i = 0; i < BLK_COLS; i++) begin : g_lane
    localparam logic [LB-1:0] IDX = LB'(i);
    if (i == 0) begin : g_first
      always_comb begin
        lane_addr[i*AW +: AW] = blocks ? {blk_base, IDX} : col_addr;
        lane_en[i]            = blocks ? dq[i] : 1'b1;
      end
    end else begin : g_rest
      always_comb begin
        lane_addr[i*AW +: AW] = blocks ? {blk_base, IDX} : '0;
        lane_en[i]            = blocks & dq[i];
      end
    end
  end

endmodule

// File: rtl/blkwr_datapath.sv
module blkwr_datapath #(
  parameter int DW       = 16,
  parameter int AW       = 9,
  parameter int BLK_COLS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cyc_valid_i,
  input  logic [2:0]             cyc_code_i,
  input  logic                   persist_i,
  input  logic [AW-1:0]          col_addr_i,
  input  logic [DW-1:0]          ras_dq_i,
  input  logic [DW-1:0]          dq_i,
  output logic [BLK_COLS*AW-1:0] lane_addr_o,
  output logic [BLK_COLS-1:0]    col_en_o,
  output logic [DW-1:0]          bit_en_o,
  output logic [DW-1:0]          wr_data_o
);
  import blkwr_pkg::*;

  localparam int LAW = BLK_COLS * AW;

  cyc_class_t           cls;
  logic                 go;
  logic [DW-1:0]        mask_q, color_q, bit_en_n, data_n;
  logic [LAW-1:0]       addr_n;
  logic [BLK_COLS-1:0]  en_n;

  assign cls = classify(cyc_code_i);
  assign go  = cyc_valid_i & (cls.writes | cls.blocks);

  blkwr_store #(.DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_mask  (cyc_valid_i & cls.ld_mask),
    .ld_color (cyc_valid_i & cls.ld_color),
    .din      (dq_i),
    .mask_q   (mask_q),
    .color_q  (color_q)
  );

  blkwr_bitsel #(.DW(DW)) u_bitsel (
    .bitmasked (cls.bitmasked),
    .persist   (persist_i),
    .ras_dq    (ras_dq_i),
    .mask_q    (mask_q),
    .bit_en    (bit_en_n)
  );

  blkwr_lanes #(.DW(DW), .AW(AW), .BLK_COLS(BLK_COLS)) u_lanes (
    .blocks    (cls.blocks),
    .col_addr  (col_addr_i),
    .dq        (dq_i),
    .lane_addr (addr_n),
    .lane_en   (en_n)
  );

  assign data_n = cls.blocks ? color_q : dq_i;

  always_ff @(posedge clk) begin
    if (!rst_n || !go) begin
      lane_addr_o <= '0;
      col_en_o    <= '0;
      bit_en_o    <= '0;
      wr_data_o   <= '0;
    end else begin
      lane_addr_o <= addr_n;
      col_en_o    <= en_n;
      bit_en_o    <= bit_en_n;
      wr_data_o   <= data_n;
    end
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (col_en_o == '0 && bit_en_o == '0 && wr_data_o == '0)); // R8
  AST_PLAIN_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_i && cyc_code_i == 3'd1) |=>
      (bit_en_o == '1 && col_en_o == BLK_COLS'(1) && wr_data_o == $past(dq_i))); // R3
  AST_LIVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cls.bitmasked && !persist_i) |=> bit_en_o == $past(ras_dq_i)); // R4
  AST_HELD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cls.bitmasked && persist_i) |=> bit_en_o == $past(mask_q)); // R5
  AST_BLOCK_USES_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cls.blocks) |=> wr_data_o == $past(color_q)); // R6
  AST_LOAD_WRITES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_i && (cls.ld_mask || cls.ld_color)) |=> col_en_o == '0); // R2
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cls.writes) |=> $onehot0(col_en_o) && col_en_o[0]); // R7

endmodule

// File: tb/sim_blkwr_datapath.sv
module sim_blkwr_datapath;

  localparam int DW = 16, AW = 9, NC = 4, LB = 2;
  localparam int N  = 12;

  // [80:78] code [77] persist [76:68] col [67:52] ras_dq [51:36] dq
  // [35:32] exp col_en [31:16] exp bit_en [15:0] exp data
  localparam logic [80:0] TBL [N] = '{
    {3'd6, 1'b0, 9'h000, 16'h0000, 16'hA5C3, 4'h0, 16'h0000, 16'h0000}, // R2
    {3'd5, 1'b0, 9'h000, 16'h0000, 16'h0F0F, 4'h0, 16'h0000, 16'h0000}, // R2
    {3'd1, 1'b0, 9'h123, 16'h0000, 16'h1234, 4'h1, 16'hFFFF, 16'h1234}, // R3
    {3'd2, 1'b0, 9'h045, 16'h00FF, 16'hBEEF, 4'h1, 16'h00FF, 16'hBEEF}, // R4
    {3'd2, 1'b1, 9'h046, 16'hFFFF, 16'hCAFE, 4'h1, 16'h0F0F, 16'hCAFE}, // R5
    {3'd3, 1'b0, 9'h1FD, 16'h0000, 16'h000A, 4'hA, 16'hFFFF, 16'hA5C3}, // R6
    {3'd4, 1'b0, 9'h0A2, 16'h3C3C, 16'h0005, 4'h5, 16'h3C3C, 16'hA5C3}, // R7
    {3'd4, 1'b1, 9'h013, 16'h0000, 16'h000F, 4'hF, 16'h0F0F, 16'hA5C3}, // R7
    {3'd0, 1'b0, 9'h077, 16'hFFFF, 16'hFFFF, 4'h0, 16'h0000, 16'h0000}, // R8
    {3'd6, 1'b0, 9'h000, 16'h0000, 16'h0001, 4'h0, 16'h0000, 16'h0000}, // R2
    {3'd3, 1'b0, 9'h100, 16'h0000, 16'h00F0, 4'h0, 16'hFFFF, 16'h0001}, // R6
    {3'd1, 1'b1, 9'h0FF, 16'h0000, 16'h0000, 4'h1, 16'hFFFF, 16'h0000}  // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_valid_i = 1'b0, persist_i = 1'b0;
  logic [2:0] cyc_code_i = '0;
  logic [AW-1:0] col_addr_i = '0;
  logic [DW-1:0] ras_dq_i = '0, dq_i = '0;
  logic [NC*AW-1:0] lane_addr_o;
  logic [NC-1:0] col_en_o;
  logic [DW-1:0] bit_en_o, wr_data_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  blkwr_datapath #(.DW(DW), .AW(AW), .BLK_COLS(NC)) u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(req, "col_en", 32'(col_en_o), 32'h0);
    chk(req, "bit_en", 32'(bit_en_o), 32'h0);
    chk(req, "data",   32'(wr_data_o), 32'h0);
  endtask

  // drive one beat at a falling edge; return at the next falling edge
  task automatic beat(input logic [2:0] code, input logic pers,
                      input logic [AW-1:0] col, input logic [DW-1:0] ras,
                      input logic [DW-1:0] d);
    @(negedge clk);
    cyc_valid_i = 1'b1; cyc_code_i = code; persist_i = pers;
    col_addr_i = col; ras_dq_i = ras; dq_i = d;
    @(negedge clk);
    cyc_valid_i = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] code, input logic pers);
    case (code)
      3'd1: return "R3";
      3'd2: return pers ? "R5" : "R4";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5, 3'd6: return "R2";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    quiet("R1");                               // R1: outputs zero in reset
    rst_n = 1'b1;
    @(negedge clk);
    quiet("R1");                               // R1: first cycle after reset

    // R1: cleared color register written by a block write
    beat(3'd3, 1'b0, 9'h008, 16'h0000, 16'h000F);
    chk("R1", "color after reset", 32'(wr_data_o), 32'h0);
    chk("R1", "col_en", 32'(col_en_o), 32'hF);
    // R1: cleared mask register in held mode
    beat(3'd2, 1'b1, 9'h009, 16'hFFFF, 16'h5555);
    chk("R1", "mask after reset", 32'(bit_en_o), 32'h0);

    // vector table
    for (int k = 0; k < N; k++) begin
      logic [80:0] v;
      string t;
      v = TBL[k];
      t = tag_of(v[80:78], v[77]);
      beat(v[80:78], v[77], v[76:68], v[67:52], v[51:36]);
      chk(t, "col_en", 32'(col_en_o),  32'(v[35:32]));
      chk(t, "bit_en", 32'(bit_en_o),  32'(v[31:16]));
      chk(t, "data",   32'(wr_data_o), 32'(v[15:0]));
      if (v[80:78] == 3'd3 || v[80:78] == 3'd4) begin
        for (int i = 0; i < NC; i++)
          chk("R6", "lane addr", 32'(lane_addr_o[i*AW +: AW]),
              32'({v[76:68+LB], LB'(i)}));
      end else if (v[80:78] == 3'd1 || v[80:78] == 3'd2) begin
        chk("R7", "lane0 addr", 32'(lane_addr_o[AW-1:0]), 32'(v[76:68]));
      end
      @(negedge clk);
      quiet("R8");                             // R8: gone after one clock
    end

    // R2/R5: load mask then held-mode write on the next clock
    @(negedge clk);
    cyc_valid_i = 1'b1; cyc_code_i = 3'd5; dq_i = 16'h1234;
    @(negedge clk);
    cyc_code_i = 3'd2; persist_i = 1'b1; ras_dq_i = 16'hFFFF; dq_i = 16'h9999;
    @(negedge clk);
    chk("R5", "new mask used at once", 32'(bit_en_o), 32'h1234);
    chk("R5", "data", 32'(wr_data_o), 32'h9999);
    cyc_valid_i = 1'b0;
    @(negedge clk);
    quiet("R8");

    // R8: write code present but beat not valid
    cyc_code_i = 3'd1; dq_i = 16'hFFFF;
    @(negedge clk);
    quiet("R8");
    // R8: reserved code 7 writes nothing
    beat(3'd7, 1'b0, 9'h011, 16'hFFFF, 16'hFFFF);
    quiet("R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule